// File: doc/BRIEF.md
# Strobed Watchdog Timer with Sticky Expiry Flag

This block is a down-counting watchdog that advances on a slow timebase tick rather than on every clock. Software sets a timeout through a control register and keeps the watchdog alive by writing a reload strobe bit. If the count runs out before the next strobe, the block raises a sticky expiry flag. An interrupt-enable bit decides whether that flag drives the interrupt output.

The control register has a lock bit that is checked on each write. When a write carries the lock bit set, the timeout field is left alone and only the strobe takes effect. This lets software reload the watchdog without having to know or rewrite the current timeout. A timeout of zero switches the watchdog off. The flag stays set until software reads the flag register, and that read clears it.

The block has no data stream, so every pin is a plain control or status signal. The register port has no back-pressure: a write is taken on the clock edge where `wr_en` is high, and `rdata` reflects the addressed register in the same cycle as `rd_en`.

Top module: `strobed_watchdog`

## Requirements
- R1: After reset the timeout field is 0, the expiry flag is 0, the interrupt enable is 0, `irq_o` is 0, and both registers read as 0.
- R2: The control register is at address 0. Bits [5:0] hold the timeout, bit 6 is the lock bit and bit 7 is the strobe. A write with bit 6 = 0 stores bits [5:0] as the timeout. A write with bit 6 = 1 leaves the timeout unchanged.
- R3: A control write with bit 7 = 1 reloads the counter on the next clock edge. The reload uses the timeout as it stands after that same write. The strobe then clears itself, so bit 7 reads back as 0 from that point on.
- R4: A control write with bit 7 = 0 does not reload or restart the counter.
- R5: Each tick lowers the running count by one. After a reload with timeout N (N > 0), the Nth tick sets the expiry flag, which is visible from the cycle after that tick.
- R6: While the timeout field is 0 the counter holds its value and never expires. A nonzero timeout written later without a strobe resumes the count from the held value.
- R7: The flag register is at address 1, with the flag in bit 0 and the interrupt enable in bit 1. The flag stays set until that register is read, and the read clears it. If an expiry happens in the same cycle as the read, the read returns the old value and the flag is left set.
- R8: A write to address 1 stores bit 1 as the interrupt enable and ignores bit 0. `irq_o` is high exactly when both the flag and the enable are set. The flag is set on expiry whatever the enable is.
- R9: After an expiry the counter stays at zero and gives no further expiry until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase pulse that advances the count |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 1 clears the flag) |
| addr | input | 1 | Register select: 0 = control, 1 = flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, 0 when `rd_en` is low |
| irq_o | output | 1 | Watchdog interrupt |

## Verification
A counter that reloads from a stale timeout, or that reloads without a strobe, shifts the cycle at which the flag appears by one or more ticks. The bench therefore reads the flag exactly one tick before and exactly at the expected expiry. A flag cleared too early or held too long shows on the next read of address 1. A wrong enable gating shows on `irq_o` in the cycle right after the expiring tick. Lock-bit and disable faults show on the control register readback, or as an expiry that arrives when none is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 1'b0,
    REG_FLAG = 1'b1
  } wdt_reg_e;

  localparam int unsigned FLAG_BIT = 0;
  localparam int unsigned IE_BIT   = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TO_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [wdt_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       expire_i,
  output logic [DATA_W-1:0]          rdata,
  output logic [TO_W-1:0]            timeout_o,
  output logic                       strobe_o,
  output logic                       flag_o,
  output logic                       ie_o
);
  import wdt_pkg::*;

  localparam int unsigned STB_BIT  = DATA_W - 1;
  localparam int unsigned LOCK_BIT = DATA_W - 2;

  logic            ctrl_wr, flag_wr, flag_rd;
  logic [TO_W-1:0] timeout_q;
  logic            strobe_q, flag_q, ie_q;

  assign ctrl_wr = wr_en && (addr == REG_CTRL);
  assign flag_wr = wr_en && (addr == REG_FLAG);
  assign flag_rd = rd_en && (addr == REG_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= '0;
      strobe_q  <= 1'b0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (ctrl_wr && !wdata[LOCK_BIT]) timeout_q <= wdata[TO_W-1:0];
      // strobe lives for one cycle unless written again
      strobe_q <= ctrl_wr && wdata[STB_BIT];
      if (flag_wr) ie_q <= wdata[IE_BIT];
      if (expire_i)     flag_q <= 1'b1;
      else if (flag_rd) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == REG_CTRL) begin
        rdata[TO_W-1:0] = timeout_q;
        rdata[STB_BIT]  = strobe_q;
      end else begin
        rdata[FLAG_BIT] = flag_q;
        rdata[IE_BIT]   = ie_q;
      end
    end
  end

  assign timeout_o = timeout_q;
  assign strobe_o  = strobe_q;
  assign flag_o    = flag_q;
  assign ie_o      = ie_q;

  AST_LOCK_HOLDS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[LOCK_BIT]) |=> (timeout_q == $past(timeout_q))); // R2
  AST_STROBE_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !ctrl_wr) |=> !strobe_q); // R3
  AST_ZERO_STROBE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[STB_BIT]) |=> !strobe_q); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_rd) |=> flag_q); // R7
  AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !expire_i) |=> !flag_q); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned TO_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            reload_i,
  input  logic [TO_W-1:0] timeout_i,
  output logic            expire_o
);
  localparam logic [TO_W-1:0] ONE = TO_W'(1);

  logic [TO_W-1:0] count_q;
  logic            enabled;

  assign enabled = (timeout_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (reload_i) begin
      count_q <= timeout_i;
    end else if (tick_i && enabled && (count_q != '0)) begin
      count_q <= count_q - ONE;
    end
  end

  // a reload in the same cycle takes priority over the expiring tick
  assign expire_o = tick_i && !reload_i && enabled && (count_q == ONE);

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (count_q == $past(timeout_i))); // R3
  AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((timeout_i == '0) && !reload_i) |=> (count_q == $past(count_q))); // R6
  AST_EXPIRED_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((count_q == '0) && !reload_i) |=> (count_q == '0)); // R9
  AST_EXPIRE_LANDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (count_q == '0)); // R5
endmodule

// File: rtl/strobed_watchdog.sv
module strobed_watchdog #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TO_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick_i,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [wdt_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  output logic                       irq_o
);
  logic [TO_W-1:0] timeout;
  logic            strobe, expire, flag, ie;

  wdt_regs #(.DATA_W(DATA_W), .TO_W(TO_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .expire_i(expire), .rdata(rdata), .timeout_o(timeout),
    .strobe_o(strobe), .flag_o(flag), .ie_o(ie)
  );

  wdt_counter #(.TO_W(TO_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(strobe),
    .timeout_i(timeout), .expire_o(expire)
  );

  assign irq_o = flag && ie;

  AST_EXPIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R5
  AST_NO_EXPIRE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout == '0) |-> !expire); // R6
endmodule

// File: tb/strobed_watchdog_tb_top.sv
module strobed_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam int V_TO  [NV] = '{5, 5, 1, 63, 63, 0, 3};
  localparam int V_TK  [NV] = '{4, 5, 1, 62, 63, 10, 7};
  localparam int V_EXP [NV] = '{0, 1, 1, 0, 1, 0, 1};

  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [0:0] addr = '0;
  logic [7:0] wdata = '0, rdata, d;
  logic       irq;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobed_watchdog dut_i (.clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq));

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk); wr_en = 1; addr = a; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a; #1 v = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "irq after reset", irq, 0);
    rd(0, d); chk("R1", "ctrl after reset", d, 0);
    rd(1, d); chk("R1", "flags after reset", d, 0);

    // vector table: strobe with timeout, apply ticks, read flag (R5 R6 R9)
    for (int v = 0; v < NV; v++) begin
      wr(0, 8'h80 | 8'(V_TO[v]));
      ticks(V_TK[v]);
      rd(1, d);
      chk("R5", $sformatf("vector %0d flag", v), d[0], V_EXP[v]);
    end

    // R2 lock bit
    wr(0, 8'h0A); rd(0, d); chk("R2", "timeout written", d, 10);
    wr(0, 8'h55); rd(0, d); chk("R2", "locked write keeps timeout", d, 10);
    wr(0, 8'hC2);                       // locked strobe reloads 10
    ticks(9); rd(1, d); chk("R2", "locked strobe uses old timeout, early", d[0], 0);
    ticks(1); rd(1, d); chk("R3", "locked strobe expiry", d[0], 1);

    // R3 self-clear
    wr(0, 8'h85); rd(0, d); chk("R3", "strobe reads back 0", d, 8'h05);
    // R4 zero strobe does not restart
    ticks(3); wr(0, 8'h14); ticks(2);
    rd(1, d); chk("R4", "no restart on zero strobe", d[0], 1);
    // R9 no second expiry
    ticks(30); rd(1, d); chk("R9", "no repeat expiry", d[0], 0);

    // R6 disable mid-run and resume
    wr(0, 8'h85); ticks(2); wr(0, 8'h00); ticks(10);
    rd(1, d); chk("R6", "disabled no expiry", d[0], 0);
    wr(0, 8'h03); ticks(2);
    rd(1, d); chk("R6", "resume held count, early", d[0], 0);
    ticks(1); rd(1, d); chk("R6", "resume held count expiry", d[0], 1);

    // R7 sticky and read-clear
    wr(0, 8'h82); ticks(2); repeat (5) @(negedge clk);
    rd(1, d); chk("R7", "flag sticky", d[0], 1);
    rd(1, d); chk("R7", "flag cleared by read", d[0], 0);
    wr(0, 8'h82); ticks(1);
    @(negedge clk); rd_en = 1; addr = 1; tick = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0; tick = 0;
    chk("R7", "read in expiry cycle returns old", d[0], 0);
    rd(1, d); chk("R7", "expiry wins over read", d[0], 1);

    // R8 interrupt enable
    wr(1, 8'h01); rd(1, d); chk("R8", "flag bit not writable", d, 0);
    wr(1, 8'h02); rd(1, d); chk("R8", "enable readback", d, 8'h02);
    chk("R8", "irq idle", irq, 0);
    wr(0, 8'h81); ticks(1);
    chk("R8", "irq on expiry", irq, 1);
    rd(1, d); chk("R8", "flags with enable", d, 8'h03);
    chk("R8", "irq cleared with flag", irq, 0);
    wr(1, 8'h00); wr(0, 8'h81); ticks(1);
    chk("R8", "irq masked", irq, 0);
    rd(1, d); chk("R8", "flag set while masked", d, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule